// File: doc/BRIEF.md
# Strip-Mining Vector Length Sequencer

This block is the loop controller that sits in front of a vector execution unit. Software hands it an element count of any size, together with the starting byte addresses of two source streams and one destination stream. The block then splits the job into pieces that fit the vector register length. For each piece it presents one command carrying that piece's length and the current address of every stream. After the downstream unit accepts a command, the sequencer waits for a pulse saying the piece has completed. Only then does it move the pointers on and present the next piece.

The odd-sized piece always goes first. Its length is the element count modulo the maximum vector length. Every later piece is a full-length piece. When the count divides evenly, the first piece is already a full one, so a zero-length command is never produced. After the last piece completes, a one-cycle completion pulse is raised. A job of zero elements produces only that pulse.

Control is a four-state machine:
- `S_IDLE` accepts `start`. It goes to `S_FINISH` when the count is zero and to `S_ISSUE` otherwise.
- `S_ISSUE` presents the command and moves to `S_WAIT` when `cmd_ready` is high.
- `S_WAIT` waits for `chunk_done`. It returns to `S_ISSUE` while elements remain and goes to `S_FINISH` after the last piece.
- `S_FINISH` pulses `done` and returns to `S_IDLE`.

Top module: `vl_strip_sequencer`

## Requirements
- R1: After reset, `cmd_valid` and `done` are low and stay low until `start` is applied.
- R2: For a nonzero count N with N mod 64 not zero, the first command has `cmd_vl` = N mod 64 and comes before any 64-element command.
- R3: When N is a nonzero multiple of 64, the first command carries 64. Every command after the first carries 64. No command ever carries a length of 0.
- R4: For every stream, the address of command k equals that stream's base plus 8 times the sum of the lengths of commands 0..k-1, modulo 2^32.
- R5: Exactly ceil(N/64) commands are issued per job, and their lengths sum to N.
- R6: When N is 0, `done` is high in the cycle after `start` is sampled, and no command is issued.
- R7: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_vl` and all three addresses hold. After a command is accepted, `cmd_valid` stays low until `chunk_done` is sampled.
- R8: `start` has no effect while a job is in progress. This holds even when `total_len` changes at the same time. `chunk_done` has no effect while a command is waiting for acceptance.
- R9: `done` rises in the cycle after the `chunk_done` of the last piece is sampled and stays high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job; sampled only when idle |
| total_len | input | 16 | Element count N of the job |
| base_a | input | 32 | Byte address of the first element of source stream A |
| base_b | input | 32 | Byte address of the first element of source stream B |
| base_c | input | 32 | Byte address of the first element of destination stream C |
| cmd_valid | output | 1 | A piece command is presented |
| cmd_ready | input | 1 | Downstream accepts the presented command |
| cmd_vl | output | 7 | Element count of the presented piece (1..64) |
| cmd_addr_a | output | 32 | Current address of stream A |
| cmd_addr_b | output | 32 | Current address of stream B |
| cmd_addr_c | output | 32 | Current address of stream C |
| chunk_done | input | 1 | Pulse: the accepted piece has completed |
| done | output | 1 | One-cycle pulse: the whole job has completed |

## Verification
The bench sweeps every count from 0 to 200 and adds a few large counts. It compares each command against an arithmetic model of the remainder-first schedule.

The sweep targets several likely faults:
- Exact multiples of 64, such as 64, 128 and 192. A design that took the remainder literally would emit a zero-length piece there.
- Counts just above a multiple, such as 65 and 129. A design that issued full pieces first would show a wrong first length there.
- Pointer advance. A design that scaled by element count instead of bytes, or advanced by 64 after the short first piece, would show drifting addresses.

Stray `start` and `chunk_done` pulses are injected while a command is stalled. A design that honoured them would restart the job or skip a piece.

// File: rtl/vlseq_pkg.sv
package vlseq_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ISSUE  = 2'd1,
        S_WAIT   = 2'd2,
        S_FINISH = 2'd3
    } seq_state_e;

    localparam int unsigned NUM_STREAMS = 3;

endpackage

// File: rtl/vlseq_first_len.sv
module vlseq_first_len #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned MAX_VL = 64,
    parameter int unsigned VL_W   = $clog2(MAX_VL + 1)
) (
    input  logic [CNT_W-1:0] total,
    output logic [VL_W-1:0]  first_vl,
    output logic             is_empty
);
    localparam int unsigned LOG_VL = $clog2(MAX_VL);

    logic [LOG_VL-1:0] residue;

    // MAX_VL is a power of two, so the modulo is the low bits of the count
    assign residue  = total[LOG_VL-1:0];
    assign is_empty = (total == '0);

    always_comb begin
        if (residue != '0) begin
            first_vl = VL_W'(residue);
        end else begin
            first_vl = VL_W'(MAX_VL);
        end
    end

    // R3: the first length is never zero for a nonzero job
    always_comb begin
        if (!is_empty) begin
            a_first_nonzero_r3: assert (first_vl != '0);
        end
    end

endmodule

// File: rtl/vlseq_ptr_unit.sv
module vlseq_ptr_unit #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned VL_W   = 7,
    parameter int unsigned SHIFT  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              advance,
    input  logic [VL_W-1:0]   step_vl,
    output logic [ADDR_W-1:0] ptr
);
    logic [ADDR_W-1:0] step_bytes;

    assign step_bytes = ADDR_W'(step_vl) << SHIFT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= base;
        end else if (advance) begin
            ptr <= ptr + step_bytes;
        end
    end

    // R4: an advance moves the pointer by exactly the scaled piece length
    p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |=> (ptr == $past(ptr) + ($past(ADDR_W'(step_vl)) << SHIFT)));

endmodule

// File: rtl/vl_strip_sequencer.sv
module vl_strip_sequencer
    import vlseq_pkg::*;
#(
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned MAX_VL     = 64,
    parameter int unsigned ELEM_BYTES = 8,
    localparam int unsigned VL_W      = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  total_len,
    input  logic [ADDR_W-1:0] base_a,
    input  logic [ADDR_W-1:0] base_b,
    input  logic [ADDR_W-1:0] base_c,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [VL_W-1:0]   cmd_vl,
    output logic [ADDR_W-1:0] cmd_addr_a,
    output logic [ADDR_W-1:0] cmd_addr_b,
    output logic [ADDR_W-1:0] cmd_addr_c,
    input  logic              chunk_done,
    output logic              done
);
    localparam int unsigned SHIFT = $clog2(ELEM_BYTES);

    seq_state_e state_q, state_d;

    logic [CNT_W-1:0]  rem_q;
    logic [VL_W-1:0]   vl_q;
    logic [VL_W-1:0]   first_vl;
    logic              job_empty;
    logic              begin_job;
    logic              piece_done;
    logic              last_piece;
    logic [ADDR_W-1:0] base_arr [NUM_STREAMS];
    logic [ADDR_W-1:0] ptr_arr  [NUM_STREAMS];

    vlseq_first_len #(
        .CNT_W (CNT_W),
        .MAX_VL(MAX_VL),
        .VL_W  (VL_W)
    ) u_first (
        .total   (total_len),
        .first_vl(first_vl),
        .is_empty(job_empty)
    );

    assign base_arr[0] = base_a;
    assign base_arr[1] = base_b;
    assign base_arr[2] = base_c;

    assign begin_job  = (state_q == S_IDLE) && start;
    assign piece_done = (state_q == S_WAIT) && chunk_done;
    assign last_piece = (rem_q == CNT_W'(vl_q));

    for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_stream
        vlseq_ptr_unit #(
            .ADDR_W(ADDR_W),
            .VL_W  (VL_W),
            .SHIFT (SHIFT)
        ) u_ptr (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (begin_job),
            .base   (base_arr[g]),
            .advance(piece_done),
            .step_vl(vl_q),
            .ptr    (ptr_arr[g])
        );
    end

    assign cmd_addr_a = ptr_arr[0];
    assign cmd_addr_b = ptr_arr[1];
    assign cmd_addr_c = ptr_arr[2];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // remaining count and current piece length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            vl_q  <= '0;
        end else if (begin_job) begin
            rem_q <= total_len;
            vl_q  <= first_vl;
        end else if (piece_done) begin
            rem_q <= rem_q - CNT_W'(vl_q);
            vl_q  <= VL_W'(MAX_VL);
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        cmd_valid = 1'b0;
        done      = 1'b0;
        cmd_vl    = vl_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    state_d = job_empty ? S_FINISH : S_ISSUE;
                end
            end
            S_ISSUE: begin
                cmd_valid = 1'b1;
                if (cmd_ready) begin
                    state_d = S_WAIT;
                end
            end
            S_WAIT: begin
                if (chunk_done) begin
                    state_d = last_piece ? S_FINISH : S_ISSUE;
                end
            end
            S_FINISH: begin
                done    = 1'b1;
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> (!cmd_valid && !done));

    p_vl_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_vl != '0 && cmd_vl <= VL_W'(MAX_VL)));

    p_later_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (piece_done && !last_piece) |=> (cmd_valid && cmd_vl == VL_W'(MAX_VL)));

    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ISSUE || state_q == S_WAIT) |-> (rem_q >= CNT_W'(vl_q)));

    p_valid_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_vl) &&
            $stable(cmd_addr_a) && $stable(cmd_addr_b) && $stable(cmd_addr_c)));

    p_wait_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && !chunk_done) |=> !cmd_valid);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (piece_done && last_piece) |=> done);

endmodule

// File: tb/vl_strip_sequencer_test.sv
module vl_strip_sequencer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] total_len = '0;
    logic [31:0] base_a = '0, base_b = '0, base_c = '0;
    logic        cmd_valid, cmd_ready = 1'b0;
    logic [6:0]  cmd_vl;
    logic [31:0] cmd_addr_a, cmd_addr_b, cmd_addr_c;
    logic        chunk_done = 1'b0;
    logic        done;

    int nvec = 0;
    int nbad = 0;

    always #5 clk = ~clk;

    vl_strip_sequencer uut (
        .clk(clk), .rst_n(rst_n), .start(start), .total_len(total_len),
        .base_a(base_a), .base_b(base_b), .base_c(base_c),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_vl(cmd_vl),
        .cmd_addr_a(cmd_addr_a), .cmd_addr_b(cmd_addr_b), .cmd_addr_c(cmd_addr_c),
        .chunk_done(chunk_done), .done(done)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one job; stall cycles of cmd_ready held low per piece
    task automatic run_job(input int n, input logic [31:0] a, input logic [31:0] b,
                           input logic [31:0] c, input int stall);
        int rem;
        int vl;
        int pieces;
        int vl_sum;
        logic [31:0] pa, pb, pc;
        rem = n;
        vl = (n % 64 != 0) ? n % 64 : 64;
        pa = a; pb = b; pc = c;
        pieces = 0;
        vl_sum = 0;
        @(negedge clk);
        total_len = 16'(n); base_a = a; base_b = b; base_c = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (n == 0) begin
            chk("R6 done after empty start", done, 1);
            chk("R6 no command", cmd_valid, 0);
            @(negedge clk);
            chk("R9 done one cycle", done, 0);
            chk("R6 no command later", cmd_valid, 0);
            return;
        end
        while (rem > 0) begin
            chk("R7 valid presented", cmd_valid, 1);
            if (pieces == 0 && n % 64 != 0) chk("R2 first length", cmd_vl, vl);
            else chk("R3 full length", cmd_vl, vl);
            chk("R4 addr A", cmd_addr_a, pa);
            chk("R4 addr B", cmd_addr_b, pb);
            chk("R4 addr C", cmd_addr_c, pc);
            for (int s = 0; s < stall; s++) begin
                if (s == 0) begin
                    chunk_done = 1'b1; start = 1'b1; total_len = 16'hFFFF;
                end
                @(negedge clk);
                chunk_done = 1'b0; start = 1'b0;
                chk("R8 stray inputs ignored valid", cmd_valid, 1);
                chk("R8 stray inputs ignored vl", cmd_vl, vl);
                chk("R7 hold addr A", cmd_addr_a, pa);
                chk("R7 hold addr C", cmd_addr_c, pc);
            end
            cmd_ready = 1'b1;
            @(negedge clk);
            cmd_ready = 1'b0;
            chk("R7 valid drops after accept", cmd_valid, 0);
            @(negedge clk);
            chk("R7 no new command before chunk_done", cmd_valid, 0);
            chk("R9 no early done", done, 0);
            chunk_done = 1'b1;
            @(negedge clk);
            chunk_done = 1'b0;
            pieces++;
            vl_sum += vl;
            rem -= vl;
            pa = pa + 32'(vl * 8); pb = pb + 32'(vl * 8); pc = pc + 32'(vl * 8);
            vl = 64;
        end
        chk("R9 done after last piece", done, 1);
        chk("R5 piece count", pieces, (n + 63) / 64);
        chk("R5 length sum", vl_sum, n);
        @(negedge clk);
        chk("R9 done one cycle", done, 0);
        chk("R5 no extra command", cmd_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset valid", cmd_valid, 0);
        chk("R1 reset done", done, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle valid", cmd_valid, 0);
        chk("R1 idle done", done, 0);
        run_job(0, 32'h1000, 32'h2000, 32'h3000, 0);
        run_job(64, 32'h1000, 32'h2000, 32'h3000, 1);
        run_job(65, 32'h1000, 32'h2000, 32'h3000, 2);
        run_job(200, 32'h4000, 32'h8000, 32'hC000, 1);
        for (int n = 0; n <= 200; n++) begin
            run_job(n, 32'(n * 16), 32'h0010_0000 + 32'(n), 32'hFFFF_FF00, n % 3);
        end
        run_job(1000, 32'h0, 32'h100, 32'h200, 0);
        run_job(65535, 32'hFFFF_F000, 32'h0, 32'h8000_0000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule